// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns their full 64-bit product. It works one multiplier bit per clock. A single 64-bit register holds the result. At the start its lower half holds the multiplier bits and its upper half holds the running partial sum. On every cycle, the block adds the latched multiplicand into the upper half when the register's lowest bit is one. The whole register then moves right by one place. The carry of that add enters at the top, and the consumed multiplier bit drops off the bottom.

A caller raises `start` for one cycle while the unit is idle, with both operands on the inputs. After 32 cycles the block raises `done` for one cycle. From then until the next accepted start, `product` holds the final value.

The adder for the upper half is a combinational instance, and a parameter selects its structure. One option is a bit-serial carry chain, which is small. The other is a conditional-sum tree, which makes two candidate results for every block and chooses between them with a logarithmic number of multiplexer levels. Both options must give the same product bit for bit.

Top module: `shift_add_mul`

## Requirements
- R1: When `start` is high and `busy` is low at a rising edge, the operands are latched. After that edge, `product` equals {32'h0, multiplier} and `busy` is 1.
- R2: Each busy cycle performs one step. If product bit 0 is 1, the 33-bit sum of product[63:32] and the multiplicand replaces product[63:32]. The register then shifts right by one, product[0] is discarded, and bit 63 takes the carry of that sum (0 when no add took place).
- R3: Exactly 32 steps follow an accepted start. `done` is 1 for exactly one cycle, after the 32nd rising edge that follows the start edge, and `busy` is 0 from that same point.
- R4: When `done` is 1, `product` equals the full 64-bit unsigned product of the two latched operands.
- R5: A `start` pulse that arrives while `busy` is 1 has no effect. The running operation keeps its operands and its timing.
- R6: While idle, `product` holds its value until the next accepted start.
- R7: A synchronous active-high `rst` clears `product` to 0 and sets `busy` and `done` to 0 after the next rising edge, and it aborts any running operation.
- R8: The parameter `KIND` selects the accumulate adder: ADD_RIPPLE or ADD_CONDSUM. Every choice gives identical `product` values in every cycle.
- R9: A start presented in the same cycle that `done` is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication; honoured only while idle |
| mcand | input | 32 | Multiplicand, sampled on the accepting edge |
| mplier | input | 32 | Multiplier, sampled on the accepting edge |
| product | output | 64 | Product register; final result once `done` is seen |
| done | output | 1 | One-cycle pulse when the result is complete |
| busy | output | 1 | High while steps are in progress |

## Verification
A step that adds or shifts wrongly shows up in `product` one cycle after that step. The bench compares the first step against a model it computes itself, and compares the final value against the true product. A miscounted iteration counter moves `done` off the 32nd cycle or lets `busy` remain high, and this is seen in the cycle where the pulse was due. A fault in one adder structure shows up as a difference between two instances built with different `KIND` values as soon as a sum that depends on the faulty carry path is selected.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [0:0] {
    ADD_RIPPLE  = 1'b0,
    ADD_CONDSUM = 1'b1
  } adder_kind_e;
endpackage

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  always_comb begin
    logic c;
    c = cin;
    for (int i = 0; i < W; i++) begin
      sum[i] = a[i] ^ b[i] ^ c;
      c      = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    cout = c;
  end
endmodule

// File: rtl/condsum_add.sv
module condsum_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  if ((W & (W - 1)) != 0) begin : g_bad_width
    $error("condsum_add needs a power-of-two width");
  end

  // sel0/sel1: candidate sums for an incoming carry of 0/1.
  // k0/k1: candidate carry-out of each block, kept at the block's lowest bit.
  logic [W-1:0] sel0, sel1, k0, k1;

  always_comb begin
    sel0 = a ^ b;
    sel1 = ~(a ^ b);
    k0   = a & b;
    k1   = a | b;
    for (int blk = 1; blk < W; blk = blk * 2) begin
      for (int base = 0; base + 2 * blk <= W; base = base + 2 * blk) begin
        logic lo0, lo1, hi0, hi1;
        lo0 = k0[base];
        lo1 = k1[base];
        hi0 = k0[base + blk];
        hi1 = k1[base + blk];
        for (int j = 0; j < blk; j++) begin
          logic t0, t1;
          t0 = lo0 ? sel1[base + blk + j] : sel0[base + blk + j];
          t1 = lo1 ? sel1[base + blk + j] : sel0[base + blk + j];
          sel0[base + blk + j] = t0;
          sel1[base + blk + j] = t1;
        end
        k0[base] = lo0 ? hi1 : hi0;
        k1[base] = lo1 ? hi1 : hi0;
      end
    end
    sum  = cin ? sel1 : sel0;
    cout = cin ? k1[0] : k0[0];
  end
endmodule

// File: rtl/acc_adder.sv
module acc_adder
  import mul_pkg::*;
#(
  parameter int          W    = 32,
  parameter adder_kind_e KIND = ADD_CONDSUM
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  if (KIND == ADD_RIPPLE) begin : g_ripple
    ripple_add #(.W(W)) u_add (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));
  end else begin : g_condsum
    condsum_add #(.W(W)) u_add (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));
  end

  // R8: whichever structure is built, it must equal plain binary addition
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      a_r8_adder_exact: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("adder structure disagrees with arithmetic sum");
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int          W    = 32,
  parameter adder_kind_e KIND = ADD_CONDSUM
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done,
  output logic           busy
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W);

  logic [PW-1:0] prod_q;
  logic [W-1:0]  mcand_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  // named internal events
  logic accept, add_fire, last_iter;
  assign accept    = start && !busy_q;
  assign add_fire  = busy_q && prod_q[0];
  assign last_iter = busy_q && (cnt_q == CW'(W - 1));

  logic [W-1:0] add_sum;
  logic         add_cout;

  acc_adder #(.W(W), .KIND(KIND)) u_acc (
    .a   (prod_q[PW-1:W]),
    .b   (mcand_q),
    .cin (1'b0),
    .sum (add_sum),
    .cout(add_cout)
  );

  // one step: keep or replace the upper half, then shift right with the carry on top
  function automatic logic [PW-1:0] step_next(input logic [PW-1:0] p, input logic fire,
                                              input logic [W-1:0] s, input logic co);
    logic [W-1:0] hi;
    hi = fire ? s : p[PW-1:W];
    return {fire & co, hi, p[W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        prod_q  <= {{W{1'b0}}, mplier};
        mcand_q <= mcand;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        prod_q <= step_next(prod_q, add_fire, add_sum, add_cout);
        cnt_q  <= cnt_q + CW'(1);
        if (last_iter) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign product = prod_q;
  assign done    = done_q;
  assign busy    = busy_q;

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    accept |=> (prod_q == {{W{1'b0}}, $past(mplier)}) && busy_q);

  a_r2_plain_shift: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !prod_q[0]) |=> !prod_q[PW-1] && (prod_q[PW-2:W-1] == $past(prod_q[PW-1:W])));

  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    last_iter |=> done_q && !busy_q);

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  a_r5_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_iter) |=> busy_q && (cnt_q == $past(cnt_q) + CW'(1)));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !accept) |=> $stable(prod_q));

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (prod_q == '0) && !busy_q && !done_q && (cnt_q == '0));
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  import mul_pkg::*;

  logic        clk = 1'b0;
  logic        rst, start;
  logic [31:0] mcand, mplier;
  logic [63:0] product, product_rip;
  logic        done, busy, done_rip, busy_rip;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  shift_add_mul #(.W(32), .KIND(ADD_CONDSUM)) uut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product), .done(done), .busy(busy));

  shift_add_mul #(.W(32), .KIND(ADD_RIPPLE)) uut_rip (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product_rip), .done(done_rip), .busy(busy_rip));

  // bench model of one step: add the shifted multiplicand to the whole register, then halve
  function automatic logic [63:0] ref_step(input logic [31:0] a, input logic [63:0] p);
    logic [64:0] wide;
    wide = {1'b0, p} + (p[0] ? ({33'd0, a} << 32) : 65'd0);
    return wide[64:1];
  endfunction

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    return 64'(a) * 64'(b);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 load", product, {32'h0, b});
    chk("R1 busy", 64'(busy), 64'd1);
  endtask

  // runs the 32 steps; a start is pushed in before edge 'poke' (0 means none)
  task automatic finish(input logic [31:0] a, input logic [31:0] b, input int poke);
    for (int i = 1; i <= 32; i++) begin
      if (i == poke) begin
        mcand = ~a; mplier = ~b; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (i == 1) chk("R2 first step", product, ref_step(a, {32'h0, b}));
      if (i == 31) chk("R3 no early done", {62'd0, done, busy}, 64'd1);
    end
    chk("R3 done pulse and idle", {62'd0, done, busy}, 64'd2);
    chk(poke != 0 ? "R5 start while busy ignored" : "R4 product", product, ref_mul(a, b));
    chk("R8 adders agree", product_rip, product);
  endtask

  task automatic settle(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    chk("R3 done falls", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk("R6 hold while idle", product, ref_mul(a, b));
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] x, y;
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R7 reset state", {product[61:0], done, busy}, 64'd0);

    // directed corner cases
    launch(32'h0, 32'hFFFF_FFFF);             finish(32'h0, 32'hFFFF_FFFF, 0);             settle(32'h0, 32'hFFFF_FFFF);
    launch(32'hFFFF_FFFF, 32'hFFFF_FFFF);     finish(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);     settle(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    launch(32'h1, 32'hFFFF_FFFF);             finish(32'h1, 32'hFFFF_FFFF, 0);             settle(32'h1, 32'hFFFF_FFFF);
    launch(32'hAAAA_AAAA, 32'h5555_5555);     finish(32'hAAAA_AAAA, 32'h5555_5555, 0);     settle(32'hAAAA_AAAA, 32'h5555_5555);
    launch(32'h8000_0000, 32'h8000_0001);     finish(32'h8000_0000, 32'h8000_0001, 0);     settle(32'h8000_0000, 32'h8000_0001);

    // R5: starts pushed in while busy, early, mid and on the last step
    launch(32'hDEAD_BEEF, 32'h1234_5678);     finish(32'hDEAD_BEEF, 32'h1234_5678, 2);
    launch(32'hCAFE_F00D, 32'hFFFF_0001);     finish(32'hCAFE_F00D, 32'hFFFF_0001, 17);
    launch(32'h7FFF_FFFF, 32'hF0F0_F0F1);     finish(32'h7FFF_FFFF, 32'hF0F0_F0F1, 32);
    settle(32'h7FFF_FFFF, 32'hF0F0_F0F1);

    // R9: back-to-back start in the done cycle
    launch(32'h0001_0003, 32'h0000_0007);     finish(32'h0001_0003, 32'h0000_0007, 0);
    mcand = 32'hFEDC_BA98; mplier = 32'h0F0F_0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 back-to-back load", product, {32'h0, 32'h0F0F_0F0F});
    finish(32'hFEDC_BA98, 32'h0F0F_0F0F, 0);
    settle(32'hFEDC_BA98, 32'h0F0F_0F0F);

    // constrained random operands: dense, sparse and full-range mixes
    for (int n = 0; n < 40; n++) begin
      x = $urandom();
      y = $urandom();
      if (n % 4 == 1) y = y & $urandom() & $urandom();
      if (n % 4 == 2) x = x | $urandom();
      launch(x, y);
      finish(x, y, 0);
    end
    settle(x, y);

    // R7: reset in the middle of an operation
    launch(32'h1357_9BDF, 32'h2468_ACE0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset aborts", {product[61:0], done, busy}, 64'd0);
    chk("R7 reset product upper", {62'd0, product[63:62]}, 64'd0);
    chk("R8 adders agree after reset", product_rip, product);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule